// File: doc/BRIEF.md
# Burst Threshold Pin-Strap Programmer

This block runs once at power-up to read a set of burst-mode thresholds from an external resistor divider. A start pulse begins the sequence. The block turns on a test current source that feeds the divider node and waits a fixed charge time. It then requests an ADC conversion and latches the first reading (A), taken with the source on. Next it switches the source off and lets the node settle. It requests a second conversion and latches the second reading (B), taken with the source off.

The unloaded reading B becomes the stop threshold for the low-frequency burst segment. The rise A − B, which the injected current causes, selects one of eight divisor ratios from a nonlinear band table. The high-frequency burst entry threshold is B divided by that ratio. The low-frequency entry threshold is B divided by 0.6. Each division is done as a multiply by a fixed-point reciprocal taken from a small lookup. All values are 12-bit ADC codes, and results saturate at full scale. A very large rise turns burst mode off altogether. If the ADC stops answering, the source is switched off and an error is flagged.

Top module: `burst_thresh_prog`

## Requirements
- R1: A `start` pulse sampled high while idle raises `src_en`. `src_en` stays high for exactly PROG_CYC cycles before `adc_req` rises for reading A, and it stays high while reading A is requested.
- R2: Once reading A is accepted, `src_en` goes low. Then `adc_req` stays low for exactly SETTLE_CYC cycles, after which it rises for reading B with `src_en` still low.
- R3: `adc_req` stays high until the cycle in which `adc_valid` is seen high. `adc_data` is latched in that cycle, and `adc_req` is low in the next cycle.
- R4: On completion, with burst mode enabled, `stop_thr` equals reading B.
- R5: The difference d is A − B, or 0 when B > A. Each band boundary code is floor((mV·4096 + VREF_MV/2)/VREF_MV), using mV values 176, 441, 617, 833, 1087, 1391, 1754 and 2185. `ratio_code` is the number of boundary codes ≤ d, minus one, and never less than 0. Codes 0 to 7 stand for ratios 0.80, 0.75, 0.70, 0.65, 0.60, 0.55, 0.50 and 0.45.
- R6: When d is greater than the code for 2410 mV, burst mode is off. In that case `done`=1, `burst_off`=1, and `stop_thr`, `hf_entry`, `lf_entry` and `ratio_code` are all 0.
- R7: `hf_entry` = min(4095, (B·K) >> 10). K = floor((102400 + p/2)/p), where p is the selected ratio in percent (80 − 5·`ratio_code`).
- R8: `lf_entry` = min(4095, (B·1707) >> 10). This is the same formula with p = 60.
- R9: Until `done` is set, the outputs hold their defaults: `burst_off`=1, all thresholds 0, `ratio_code` 0. An accepted start clears `done` and restores the defaults. Otherwise `done` stays high until the next accepted start.
- R10: A `start` pulse that arrives while a sequence is running has no effect on the sequence or its timing.
- R11: If `adc_valid` is not seen within TIMEOUT_CYC cycles of `adc_req` rising, the block drops both `adc_req` and `src_en`, sets `err`, and leaves `done` low with the outputs at their defaults. The next accepted start clears `err`.
- R12: After reset, `src_en`, `adc_req`, `done` and `err` are 0 and `burst_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse that begins one programming sequence |
| src_en | output | 1 | Enable for the test current source |
| adc_req | output | 1 | Conversion request, held until valid |
| adc_valid | input | 1 | Strobe marking that adc_data holds a result |
| adc_data | input | ADC_W | Conversion result |
| stop_thr | output | ADC_W | Low-frequency burst stop threshold |
| hf_entry | output | ADC_W | High-frequency burst entry threshold |
| lf_entry | output | ADC_W | Low-frequency burst entry threshold |
| ratio_code | output | 3 | Selected ratio band, 0 (0.80) to 7 (0.45) |
| burst_off | output | 1 | Burst mode disabled or results not yet valid |
| done | output | 1 | Programming finished successfully |
| err | output | 1 | ADC timeout occurred |

## Verification
The bench builds the block with PROG_CYC=20, SETTLE_CYC=12 and TIMEOUT_CYC=64 instead of the microsecond-scale defaults, with VREF_MV=5000 and 12-bit data. These short windows let the bench measure the charge and settle intervals cycle by cycle. They also let it trigger an ADC timeout in under a hundred cycles, and they fit dozens of full sequences in the run. Among those sequences are one on each side of every band boundary, the disable threshold, B above A, and saturated products.

// File: rtl/bthr_pkg.sv
package bthr_pkg;

  localparam int unsigned N_BAND     = 8;
  localparam int unsigned IDX_W      = $clog2(N_BAND);
  localparam int unsigned RECIP_FRAC = 10;
  localparam int unsigned RECIP_W    = 12;
  localparam int unsigned LF_IDX     = 4;    // ratio 0.60
  localparam int unsigned OFF_MV     = 2410;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_SAMP_A,
    ST_DISCH,
    ST_SAMP_B,
    ST_CALC
  } seq_st_t;

  // lower edge of each ratio band, in millivolts of rise
  function automatic int unsigned band_mv(int unsigned i);
    case (i)
      0:       return 176;
      1:       return 441;
      2:       return 617;
      3:       return 833;
      4:       return 1087;
      5:       return 1391;
      6:       return 1754;
      7:       return 2185;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned mv_to_code(int unsigned mv, int unsigned vref_mv,
                                             int unsigned bits);
    return (mv * (32'd1 << bits) + vref_mv / 2) / vref_mv;
  endfunction

  // rounded fixed-point reciprocal of ratio (80 - 5*idx) percent
  function automatic int unsigned recip_q(int unsigned idx);
    int unsigned pct;
    pct = 80 - 5 * idx;
    return ((32'd100 << RECIP_FRAC) + pct / 2) / pct;
  endfunction

endpackage

// File: rtl/bthr_seq.sv
module bthr_seq
  import bthr_pkg::*;
#(
  parameter int unsigned PROG_CYC    = 2500,
  parameter int unsigned SETTLE_CYC  = 1250,
  parameter int unsigned TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic adc_valid,
  output logic src_en,
  output logic adc_req,
  output logic start_acc,
  output logic lat_a,
  output logic lat_b,
  output logic calc_en,
  output logic tmo
);

  localparam int unsigned CNT_MAX = (PROG_CYC > SETTLE_CYC) ?
      ((PROG_CYC > TIMEOUT_CYC) ? PROG_CYC : TIMEOUT_CYC) :
      ((SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC);
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PROG_LAST   = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYC - 1);

  seq_st_t          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    start_acc = 1'b0;
    lat_a     = 1'b0;
    lat_b     = 1'b0;
    calc_en   = 1'b0;
    tmo       = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          start_acc = 1'b1;
          st_n      = ST_CHARGE;
          cnt_n     = '0;
        end
      end
      ST_CHARGE: begin
        if (cnt_q == PROG_LAST) begin
          st_n  = ST_SAMP_A;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_SAMP_A: begin
        if (adc_valid) begin
          lat_a = 1'b1;
          st_n  = ST_DISCH;
          cnt_n = '0;
        end else if (cnt_q == TMO_LAST) begin
          tmo  = 1'b1;
          st_n = ST_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DISCH: begin
        if (cnt_q == SETTLE_LAST) begin
          st_n  = ST_SAMP_B;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_SAMP_B: begin
        if (adc_valid) begin
          lat_b = 1'b1;
          st_n  = ST_CALC;
          cnt_n = '0;
        end else if (cnt_q == TMO_LAST) begin
          tmo  = 1'b1;
          st_n = ST_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_CALC: begin
        calc_en = 1'b1;
        st_n    = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign src_en  = (st_q == ST_CHARGE) || (st_q == ST_SAMP_A);
  assign adc_req = (st_q == ST_SAMP_A) || (st_q == ST_SAMP_B);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_valid && !tmo |=> adc_req); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && adc_valid |=> !adc_req); // R3
  AST_SRC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_en) |-> $past(start)); // R1
  AST_SRC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_en) |-> $past(adc_req && adc_valid) || $past(tmo)); // R2
  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !src_en && !adc_req); // R11

endmodule

// File: rtl/bthr_band.sv
module bthr_band
  import bthr_pkg::*;
#(
  parameter int unsigned ADC_W   = 12,
  parameter int unsigned VREF_MV = 5000
) (
  input  logic [ADC_W-1:0] diff,
  output logic [IDX_W-1:0] idx,
  output logic             off
);

  localparam logic [ADC_W-1:0] OFF_CODE = ADC_W'(mv_to_code(OFF_MV, VREF_MV, ADC_W));

  logic [N_BAND-1:0] ge;
  logic [IDX_W:0]    n_ge;

  for (genvar g = 0; g < N_BAND; g++) begin : g_cmp
    localparam logic [ADC_W-1:0] BND = ADC_W'(mv_to_code(band_mv(g), VREF_MV, ADC_W));
    assign ge[g] = (diff >= BND);
  end

  always_comb begin
    n_ge = '0;
    for (int i = 0; i < N_BAND; i++) begin
      n_ge = n_ge + {{IDX_W{1'b0}}, ge[i]};
    end
  end

  assign idx = (n_ge == '0) ? '0 : IDX_W'(n_ge - 1'b1);
  assign off = (diff > OFF_CODE);

  always_comb begin
    if (off) begin
      AST_OFF_ABOVE_ALL: assert (ge == '1); // R6
    end
  end

endmodule

// File: rtl/bthr_scale.sv
module bthr_scale
  import bthr_pkg::*;
#(
  parameter int unsigned ADC_W = 12
) (
  input  logic [ADC_W-1:0]   base,
  input  logic [RECIP_W-1:0] recip,
  output logic [ADC_W-1:0]   scaled
);

  localparam int unsigned PROD_W = ADC_W + RECIP_W;
  localparam int unsigned SHF_W  = PROD_W - RECIP_FRAC;

  logic [PROD_W-1:0] prod;
  logic [SHF_W-1:0]  shf;

  assign prod   = {{RECIP_W{1'b0}}, base} * {{ADC_W{1'b0}}, recip};
  assign shf    = prod[PROD_W-1:RECIP_FRAC];
  assign scaled = (|shf[SHF_W-1:ADC_W]) ? '1 : shf[ADC_W-1:0];

endmodule

// File: rtl/burst_thresh_prog.sv
module burst_thresh_prog
  import bthr_pkg::*;
#(
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned VREF_MV     = 5000,
  parameter int unsigned PROG_CYC    = 2500,
  parameter int unsigned SETTLE_CYC  = 1250,
  parameter int unsigned TIMEOUT_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             src_en,
  output logic             adc_req,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  output logic [ADC_W-1:0] stop_thr,
  output logic [ADC_W-1:0] hf_entry,
  output logic [ADC_W-1:0] lf_entry,
  output logic [IDX_W-1:0] ratio_code,
  output logic             burst_off,
  output logic             done,
  output logic             err
);

  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic start_acc, lat_a, lat_b, calc_en, tmo;

  bthr_seq #(
    .PROG_CYC   (PROG_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (start),
    .adc_valid(adc_valid),
    .src_en   (src_en),
    .adc_req  (adc_req),
    .start_acc(start_acc),
    .lat_a    (lat_a),
    .lat_b    (lat_b),
    .calc_en  (calc_en),
    .tmo      (tmo)
  );

  logic [ADC_W-1:0] a_q, b_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (lat_a) a_q <= adc_data;
      if (lat_b) b_q <= adc_data;
    end
  end

  logic [ADC_W-1:0] diff;
  logic [IDX_W-1:0] idx;
  logic             off;

  assign diff = (a_q >= b_q) ? (a_q - b_q) : '0;

  bthr_band #(.ADC_W(ADC_W), .VREF_MV(VREF_MV)) i_band (
    .diff(diff),
    .idx (idx),
    .off (off)
  );

  logic [RECIP_W-1:0] recip_lut [N_BAND];
  for (genvar g = 0; g < N_BAND; g++) begin : g_lut
    assign recip_lut[g] = RECIP_W'(recip_q(g));
  end

  localparam logic [RECIP_W-1:0] LF_RECIP = RECIP_W'(recip_q(LF_IDX));

  logic [ADC_W-1:0] hf_calc, lf_calc;

  bthr_scale #(.ADC_W(ADC_W)) i_scale_hf (
    .base  (b_q),
    .recip (recip_lut[idx]),
    .scaled(hf_calc)
  );

  bthr_scale #(.ADC_W(ADC_W)) i_scale_lf (
    .base  (b_q),
    .recip (LF_RECIP),
    .scaled(lf_calc)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      stop_thr   <= '0;
      hf_entry   <= '0;
      lf_entry   <= '0;
      ratio_code <= '0;
      burst_off  <= 1'b1;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (start_acc) begin
        stop_thr   <= '0;
        hf_entry   <= '0;
        lf_entry   <= '0;
        ratio_code <= '0;
        burst_off  <= 1'b1;
        done       <= 1'b0;
        err        <= 1'b0;
      end else if (tmo) begin
        err <= 1'b1;
      end else if (calc_en) begin
        done <= 1'b1;
        if (off) begin
          burst_off <= 1'b1;
        end else begin
          burst_off  <= 1'b0;
          stop_thr   <= b_q;
          hf_entry   <= hf_calc;
          lf_entry   <= lf_calc;
          ratio_code <= idx;
        end
      end
    end
  end

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    burst_off |-> (stop_thr == '0) && (hf_entry == '0) && (lf_entry == '0)
                  && (ratio_code == '0)); // R6
  AST_HF_ABOVE_STOP: assert property (@(posedge clk) disable iff (!rst_s)
    done && !burst_off |-> hf_entry >= stop_thr); // R7
  AST_HF_OVER_LF: assert property (@(posedge clk) disable iff (!rst_s)
    done && !burst_off && (ratio_code >= IDX_W'(LF_IDX)) |-> hf_entry >= lf_entry); // R8
  AST_HF_UNDER_LF: assert property (@(posedge clk) disable iff (!rst_s)
    done && !burst_off && (ratio_code < IDX_W'(LF_IDX)) |-> hf_entry <= lf_entry); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_s)
    !(done && err)); // R11
  AST_NO_SRC_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !src_en || $past(start)); // R9

endmodule

// File: tb/test_burst_thresh_prog.sv
`timescale 1ns/1ps
module test_burst_thresh_prog;

  localparam int ADC_W  = 12;
  localparam int VREF   = 5000;
  localparam int PROG   = 20;
  localparam int SETTLE = 12;
  localparam int TMO    = 64;

  logic clk, rst_n, start, adc_valid;
  logic [ADC_W-1:0] adc_data;
  logic src_en, adc_req, burst_off, done, err;
  logic [ADC_W-1:0] stop_thr, hf_entry, lf_entry;
  logic [2:0] ratio_code;

  burst_thresh_prog #(
    .ADC_W(ADC_W), .VREF_MV(VREF), .PROG_CYC(PROG),
    .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)
  ) i_burst_thresh_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .src_en(src_en),
    .adc_req(adc_req), .adc_valid(adc_valid), .adc_data(adc_data),
    .stop_thr(stop_thr), .hf_entry(hf_entry), .lf_entry(lf_entry),
    .ratio_code(ratio_code), .burst_off(burst_off), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- expected-value model ----------------
  int bmv [8] = '{176, 441, 617, 833, 1087, 1391, 1754, 2185};

  function automatic int code_of(int mv);
    return (mv * 4096 + VREF / 2) / VREF;
  endfunction

  function automatic int sat_scale(int b, int pct);
    int k, r;
    k = (102400 + pct / 2) / pct;
    r = (b * k) >>> 10;
    return (r > 4095) ? 4095 : r;
  endfunction

  // ---------------- ADC responder ----------------
  int  a_v, b_v, dly;
  bit  no_resp;
  bit  r3_bad;

  initial begin
    adc_valid = 1'b0;
    adc_data  = '0;
    r3_bad    = 1'b0;
    forever begin
      @(negedge clk);
      if (adc_req && !no_resp) begin
        for (int i = 0; i < dly; i++) begin
          @(negedge clk);
          if (!adc_req) r3_bad = 1'b1;
        end
        adc_data  = src_en ? ADC_W'(a_v) : ADC_W'(b_v);
        adc_valid = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        if (adc_req) r3_bad = 1'b1;
      end
    end
  end

  // ---------------- interval monitor ----------------
  bit clr_mon;
  int phase, chg_cnt, dis_cnt, src_at_a, src_at_b;

  always @(negedge clk) begin
    if (clr_mon) begin
      phase = 0; chg_cnt = 0; dis_cnt = 0; src_at_a = 0; src_at_b = 1;
    end else begin
      if (phase == 0 && src_en) phase = 1;
      if (phase == 1 && !src_en) phase = 2;
      if (phase == 2 && adc_req) begin
        phase = 3;
        src_at_b = int'(src_en);
      end
      if (phase == 1 && src_en && !adc_req) chg_cnt++;
      if (phase == 1 && adc_req) src_at_a = int'(src_en);
      if (phase == 2 && !adc_req) dis_cnt++;
    end
  end

  task automatic kick(bit extra);
    clr_mon = 1'b1;
    @(negedge clk);
    @(posedge clk);
    clr_mon = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done cleared on start", int'(done), 0);
    chk("R9 defaults on start", int'(burst_off) + int'(stop_thr), 1);
    if (extra) begin
      repeat (PROG / 2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic run(int a, int b, int d, bit extra);
    int n, diff, idx, nge, pct;
    bit off;
    a_v = a; b_v = b; dly = d; no_resp = 1'b0;
    kick(extra);
    n = 0;
    while (!done && !err && n < 2000) begin
      @(negedge clk);
      n++;
    end
    diff = (a >= b) ? a - b : 0;
    off  = diff > code_of(2410);
    nge  = 0;
    for (int i = 0; i < 8; i++) if (diff >= code_of(bmv[i])) nge++;
    idx  = (nge == 0) ? 0 : nge - 1;
    pct  = 80 - 5 * idx;
    chk("R9 done", int'(done), 1);
    chk("R11 err clear", int'(err), 0);
    chk(extra ? "R10 charge length" : "R1 charge length", chg_cnt, PROG);
    chk("R1 source on during A", src_at_a, 1);
    chk("R2 settle length", dis_cnt, SETTLE);
    chk("R2 source off during B", src_at_b, 0);
    chk("R3 request handshake", int'(r3_bad), 0);
    chk("R6 burst_off", int'(burst_off), int'(off));
    chk("R4 stop_thr", int'(stop_thr), off ? 0 : b);
    chk("R5 ratio_code", int'(ratio_code), off ? 0 : idx);
    chk("R7 hf_entry", int'(hf_entry), off ? 0 : sat_scale(b, pct));
    chk("R8 lf_entry", int'(lf_entry), off ? 0 : sat_scale(b, 60));
    repeat (5) @(negedge clk);
    chk("R9 done held", int'(done), 1);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20250917));
    rst_n = 1'b0; start = 1'b0; clr_mon = 1'b1;
    no_resp = 1'b0; a_v = 0; b_v = 0; dly = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 src_en reset", int'(src_en), 0);
    chk("R12 adc_req reset", int'(adc_req), 0);
    chk("R12 done reset", int'(done), 0);
    chk("R12 err reset", int'(err), 0);
    chk("R12 burst_off reset", int'(burst_off), 1);
    chk("R9 thresholds reset", int'(stop_thr) + int'(hf_entry) + int'(lf_entry), 0);

    // band edges, each side
    for (int i = 0; i < 8; i++) begin
      run(1000 + code_of(bmv[i]), 1000, i % 4, 1'b0);
      run(1000 + code_of(bmv[i]) - 1, 1000, 1, 1'b0);
    end
    // disable edge
    run(1000 + code_of(2410), 1000, 2, 1'b0);
    run(1000 + code_of(2410) + 1, 1000, 0, 1'b0);
    run(4095, 0, 3, 1'b0);
    // zero rise, reversed readings, saturation
    run(1500, 1500, 0, 1'b0);
    run(800, 1200, 2, 1'b0);
    run(4095, 4095, 1, 1'b0);
    run(2200 + 1800, 2200, 4, 1'b0);
    // start while busy
    run(1600, 1000, 3, 1'b1);

    // ADC timeout
    no_resp = 1'b1;
    kick(1'b0);
    n = 0;
    while (!err && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk("R11 err set", int'(err), 1);
    chk("R11 timeout window", int'(n >= TMO && n <= PROG + TMO + 4), 1);
    chk("R11 source off", int'(src_en), 0);
    chk("R11 request off", int'(adc_req), 0);
    chk("R11 done low", int'(done), 0);
    chk("R11 defaults", int'(burst_off) + int'(stop_thr), 1);
    no_resp = 1'b0;
    repeat (3) @(negedge clk);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int b, d, a;
      b = int'($urandom_range(0, 4095));
      d = int'($urandom_range(0, 2300));
      a = b + d;
      if (a > 4095) a = 4095;
      if (($urandom_range(0, 9)) == 0) a = int'($urandom_range(0, 4095));
      run(a, b, int'($urandom_range(0, 5)), bit'($urandom_range(0, 7) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule